// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches up to 32 asynchronous external lines and turns their transitions into interrupt requests. Each line is first brought into the local clock domain through two flip-flops. A rising or falling transition is then found by comparing the synchronised level with its value one clock earlier. Per line, software enables rising detection, falling detection, both, or neither.

Every enabled transition sets a sticky pending bit. Software clears a pending bit by writing a one to it. The single interrupt output is a level: it is the OR of every pending bit that its interrupt mask bit lets through. A second output gives a one-clock pulse for each enabled transition on a line whose event mask bit is set. This pulse does not depend on the pending bits.

Software reaches the block through a small word-addressed register bus. Reads are combinational and writes take effect at the clock edge. Lines left out by the `IMPL_MASK` parameter have no logic and read as zero in every register. Software can therefore find the implemented set by writing all-ones to the rising-select register and reading it back.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After synchronous reset, every register reads zero, `irq_out` is 0 and `evt_out` is 0.
- R2: The byte offsets are: 0x00 interrupt mask, 0x04 event mask, 0x08 rising select, 0x0C falling select, 0x10 software trigger, 0x14 pending. The first four read back what was written, limited to implemented lines. Any other offset reads zero and ignores writes.
- R3: A line with its rising-select bit set and its falling-select bit clear sets its pending bit on a low-to-high transition only.
- R4: A line with its falling-select bit set and its rising-select bit clear sets its pending bit on a high-to-low transition only.
- R5: A line with both select bits set sets its pending bit on either transition.
- R6: A line with neither select bit set never sets its pending bit from its input.
- R7: Writing to offset 0x14 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 are left unchanged.
- R8: If an enabled transition and a clearing write reach the same pending bit in the same cycle, the bit ends up set.
- R9: `irq_out` is 1 exactly when some pending bit has its interrupt-mask bit set. It stays asserted until every such bit is cleared or masked.
- R10: Writing 1 to a software-trigger bit sets the matching pending bit only when that line has its rising-select or falling-select bit set. The software-trigger register always reads zero.
- R11: `evt_out` is 1 for exactly one clock per enabled transition on a line whose event-mask bit is 1. This holds whatever the line's pending bit is, and the output stays 0 when that event-mask bit is 0.
- R12: Bits of lines cleared in `IMPL_MASK` read zero in every register and never become pending. Writing all-ones to rising select and reading it back returns `IMPL_MASK`.
- R13: Input latency is fixed. `evt_out` rises after the second clock edge that follows an input change, and the pending bit reads set after the third clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 32 | Asynchronous external lines |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Combined interrupt level |
| evt_out | output | 1 | One-clock event pulse |

## Verification
The detection path is swept over every one of the 32 lines. Each line is tried with all four combinations of rising and falling select, and is driven through both a rise and a fall. This separates rising-only, falling-only, either-edge and disabled behaviour. It also separates implemented lines from tied-off ones and exposes any crossing between lines.

Directed sequences cover the remaining behaviour. They clear pending bits with partial and all-zero masks, which tells a true write-one-to-clear from a plain overwrite. They fire software triggers on enabled and disabled lines. They make a transition and a clear collide in the same cycle. They also check event pulses with the event mask off, and with the pending bit already set.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int unsigned EIRQ_LINES = 32;
    localparam int unsigned EIRQ_AW    = 5;

    typedef logic [EIRQ_LINES-1:0] line_vec_t;
    typedef logic [EIRQ_AW-1:0]    reg_addr_t;

    localparam reg_addr_t OFS_IMASK = 5'h00;
    localparam reg_addr_t OFS_EMASK = 5'h04;
    localparam reg_addr_t OFS_RISE  = 5'h08;
    localparam reg_addr_t OFS_FALL  = 5'h0C;
    localparam reg_addr_t OFS_SWT   = 5'h10;
    localparam reg_addr_t OFS_PEND  = 5'h14;

    typedef enum logic [2:0] {
        RS_IMASK,
        RS_EMASK,
        RS_RISE,
        RS_FALL,
        RS_SWT,
        RS_PEND,
        RS_NONE
    } reg_sel_e;

    typedef struct packed {
        line_vec_t imask;
        line_vec_t emask;
        line_vec_t rise;
        line_vec_t fall;
    } cfg_t;

    function automatic reg_sel_e decode_addr(input reg_addr_t a);
        reg_sel_e s;
        case (a)
            OFS_IMASK: s = RS_IMASK;
            OFS_EMASK: s = RS_EMASK;
            OFS_RISE:  s = RS_RISE;
            OFS_FALL:  s = RS_FALL;
            OFS_SWT:   s = RS_SWT;
            OFS_PEND:  s = RS_PEND;
            default:   s = RS_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/eirq_sync_edge.sv
module eirq_sync_edge
    import eirq_pkg::*;
#(
    parameter line_vec_t IMPL_MASK = '1
) (
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t pins_i,
    output line_vec_t rise_o,
    output line_vec_t fall_o
);

    for (genvar g = 0; g < EIRQ_LINES; g++) begin : g_line
        if (IMPL_MASK[g]) begin : g_impl
            logic meta_q, sync_q, prev_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                    prev_q <= 1'b0;
                end else begin
                    meta_q <= pins_i[g];
                    sync_q <= meta_q;
                    prev_q <= sync_q;
                end
            end
            assign rise_o[g] = sync_q & ~prev_q;
            assign fall_o[g] = ~sync_q & prev_q;
        end else begin : g_tied
            assign rise_o[g] = 1'b0;
            assign fall_o[g] = 1'b0;
        end
    end

endmodule

// File: rtl/eirq_cfg_regs.sv
module eirq_cfg_regs
    import eirq_pkg::*;
#(
    parameter line_vec_t IMPL_MASK = '1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  reg_sel_e  sel,
    input  line_vec_t wdata,
    output cfg_t      cfg_o
);

    cfg_t cfg_q;
    line_vec_t wval;

    assign wval = wdata & IMPL_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (sel)
                RS_IMASK: cfg_q.imask <= wval;
                RS_EMASK: cfg_q.emask <= wval;
                RS_RISE:  cfg_q.rise  <= wval;
                RS_FALL:  cfg_q.fall  <= wval;
                default:  ;
            endcase
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/eirq_pend.sv
module eirq_pend
    import eirq_pkg::*;
#(
    parameter line_vec_t IMPL_MASK = '1
) (
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t rise_en,
    input  line_vec_t fall_en,
    input  line_vec_t rise_i,
    input  line_vec_t fall_i,
    input  logic      w1c_en,
    input  logic      swt_en,
    input  line_vec_t wdata,
    output line_vec_t hit_o,
    output line_vec_t pend_o
);

    line_vec_t pend_q, set_v, clr_v, hit;

    always_comb begin
        hit   = (rise_i & rise_en) | (fall_i & fall_en);
        set_v = hit | (swt_en ? (wdata & (rise_en | fall_en)) : '0);
        clr_v = w1c_en ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= ((pend_q & ~clr_v) | set_v) & IMPL_MASK;
    end

    assign hit_o  = hit;
    assign pend_o = pend_q;

    a_r3_edge_latched: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((pend_q & $past(hit)) == $past(hit)));

    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (w1c_en && hit == '0) |=> ((pend_q & $past(wdata)) == '0));

    a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (w1c_en && (hit & wdata) != '0) |=> ((pend_q & $past(hit & wdata)) != '0));

    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!w1c_en && !swt_en && hit == '0) |=> $stable(pend_q));

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import eirq_pkg::*;
#(
    parameter logic [31:0] IMPL_MASK = 32'h0FFF_FFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] ext_in,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_out,
    output logic        evt_out
);

    reg_sel_e  sel;
    cfg_t      cfg;
    line_vec_t rise, fall, hit, pend;

    assign sel = decode_addr(bus_addr);

    eirq_sync_edge #(.IMPL_MASK(IMPL_MASK)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pins_i (ext_in),
        .rise_o (rise),
        .fall_o (fall)
    );

    eirq_cfg_regs #(.IMPL_MASK(IMPL_MASK)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .cfg_o (cfg)
    );

    eirq_pend #(.IMPL_MASK(IMPL_MASK)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .rise_en (cfg.rise),
        .fall_en (cfg.fall),
        .rise_i  (rise),
        .fall_i  (fall),
        .w1c_en  (bus_wr && sel == RS_PEND),
        .swt_en  (bus_wr && sel == RS_SWT),
        .wdata   (bus_wdata),
        .hit_o   (hit),
        .pend_o  (pend)
    );

    always_comb begin
        case (sel)
            RS_IMASK: bus_rdata = cfg.imask;
            RS_EMASK: bus_rdata = cfg.emask;
            RS_RISE:  bus_rdata = cfg.rise;
            RS_FALL:  bus_rdata = cfg.fall;
            RS_PEND:  bus_rdata = pend;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_out = |(pend & cfg.imask);
    assign evt_out = |(hit & cfg.emask);

    a_r9_irq_level_holds: assert property (@(posedge clk) disable iff (rst)
        (irq_out && !bus_wr) |=> irq_out);

    a_r11_evt_needs_emask: assert property (@(posedge clk) disable iff (rst)
        evt_out |-> (cfg.emask != '0));

    a_r12_rise_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == RS_RISE) |=> ((cfg.rise & ~IMPL_MASK) == '0));

endmodule

// File: tb/edge_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module edge_irq_ctrl_tb_top;

    localparam logic [31:0] TB_IMPL = 32'h0FFF_FFFF;
    localparam logic [4:0] A_IM = 5'h00, A_EM = 5'h04, A_RS = 5'h08,
                           A_FS = 5'h0C, A_SW = 5'h10, A_PD = 5'h14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ext = '0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out, evt_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    edge_irq_ctrl #(.IMPL_MASK(TB_IMPL)) dut_i (
        .clk(clk), .rst(rst), .ext_in(ext), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .evt_out(evt_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.5;
        chk(req, bus_rdata, exp);
    endtask

    // Change line i, check R13 latency and event, then the pending register.
    task automatic drive_line(input int i, input logic v, input logic ev_exp,
                              input logic [31:0] pend_exp, input string req);
        @(negedge clk); ext[i] = v;
        @(negedge clk); chk({req, " R13 no early event"}, {31'b0, evt_out}, 32'h0);
        @(negedge clk); chk({req, " event"}, {31'b0, evt_out}, {31'b0, ev_exp});
        @(negedge clk); chk({req, " R11 single pulse"}, {31'b0, evt_out}, 32'h0);
        rd_chk({req, " pending"}, A_PD, pend_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] pat;
        string tag;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 imask", A_IM, 0); rd_chk("R1 emask", A_EM, 0);
        rd_chk("R1 rise", A_RS, 0);  rd_chk("R1 fall", A_FS, 0);
        rd_chk("R1 swt", A_SW, 0);   rd_chk("R1 pend", A_PD, 0);
        chk("R1 irq", {31'b0, irq_out}, 0);
        chk("R1 evt", {31'b0, evt_out}, 0);

        // R2 readback and offsets
        pat = 32'hC3A5_5A3C;
        wr(A_IM, pat); wr(A_EM, ~pat); wr(A_RS, pat ^ 32'h00FF_00FF); wr(A_FS, 32'hFFFF_0001);
        rd_chk("R2 imask", A_IM, pat & TB_IMPL);
        rd_chk("R2 emask", A_EM, ~pat & TB_IMPL);
        rd_chk("R2 rise", A_RS, (pat ^ 32'h00FF_00FF) & TB_IMPL);
        rd_chk("R2 fall", A_FS, 32'hFFFF_0001 & TB_IMPL);
        wr(5'h18, 32'hFFFF_FFFF);
        rd_chk("R2 unmapped", 5'h18, 0);
        rd_chk("R2 imask untouched", A_IM, pat & TB_IMPL);
        wr(A_IM, 0); wr(A_EM, 0); wr(A_RS, 0); wr(A_FS, 0); wr(A_PD, '1);
        rd_chk("R2 clean imask", A_IM, 0);
        rd_chk("R2 clean pend", A_PD, 0);

        // R12 implemented-line probe
        wr(A_RS, '1);
        rd_chk("R12 probe", A_RS, TB_IMPL);
        wr(A_RS, 0);

        // R10 software trigger
        wr(A_SW, 32'hF);
        rd_chk("R10 disabled lines", A_PD, 0);
        wr(A_RS, 32'h2); wr(A_FS, 32'h4);
        wr(A_SW, 32'hF);
        rd_chk("R10 enabled lines", A_PD, 32'h6);
        rd_chk("R10 swt reads zero", A_SW, 0);
        wr(A_RS, '1); wr(A_SW, 32'h8000_0000);
        rd_chk("R12 unimpl swt", A_PD, 32'h6);
        wr(A_RS, 32'h2);

        // R7 write-one-to-clear
        wr(A_PD, 0);
        rd_chk("R7 zero write", A_PD, 32'h6);
        wr(A_PD, 32'h2);
        rd_chk("R7 partial", A_PD, 32'h4);

        // R9 interrupt level and mask
        chk("R9 masked", {31'b0, irq_out}, 0);
        wr(A_IM, 32'h4);
        chk("R9 unmasked", {31'b0, irq_out}, 1);
        wr(A_IM, 32'h8);
        chk("R9 other mask", {31'b0, irq_out}, 0);
        wr(A_IM, 32'h4);
        chk("R9 re-enable", {31'b0, irq_out}, 1);
        wr(A_PD, 32'h4);
        chk("R9 cleared", {31'b0, irq_out}, 0);
        wr(A_IM, 0); wr(A_FS, 0);

        // R8 edge and clear in the same cycle
        wr(A_RS, 32'h1); wr(A_SW, 32'h1);
        rd_chk("R8 preset", A_PD, 32'h1);
        @(negedge clk); ext[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = A_PD; bus_wdata = 32'h1;
        @(negedge clk); bus_wr = 1'b0;
        rd_chk("R8 edge wins", A_PD, 32'h1);
        wr(A_PD, '1);

        // R11 event mask off, then event with pending already set
        drive_line(0, 1'b0, 1'b0, 32'h0, "R11 fall ignored");
        drive_line(0, 1'b1, 1'b0, 32'h1, "R11 emask off");
        wr(A_EM, 32'h1);
        drive_line(0, 1'b0, 1'b0, 32'h1, "R11 fall ignored");
        drive_line(0, 1'b1, 1'b1, 32'h1, "R11 pend already set");
        drive_line(0, 1'b0, 1'b0, 32'h1, "R11 low again");
        wr(A_PD, '1);

        // Sweep: every line, every select mode, both directions
        wr(A_EM, '1);
        for (int i = 0; i < 32; i++) begin
            for (int m = 0; m < 4; m++) begin
                logic r_on, f_on;
                r_on = m[0] && TB_IMPL[i];
                f_on = m[1] && TB_IMPL[i];
                case (m)
                    0: tag = "R6";
                    1: tag = "R3";
                    2: tag = "R4";
                    default: tag = "R5";
                endcase
                if (!TB_IMPL[i]) tag = "R12";
                wr(A_RS, m[0] ? '1 : '0);
                wr(A_FS, m[1] ? '1 : '0);
                wr(A_PD, '1);
                drive_line(i, 1'b1, r_on, r_on ? (32'h1 << i) : 32'h0,
                           $sformatf("%s line %0d rise", tag, i));
                wr(A_PD, '1);
                drive_line(i, 1'b0, f_on, f_on ? (32'h1 << i) : 32'h0,
                           $sformatf("%s line %0d fall", tag, i));
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule